// File: doc/BRIEF.md
# Twelve-Point Folded Cosine Transform Datapath

This block takes a vector of twelve samples and returns ten cosine-transform coefficients, plus two lanes held at zero. It runs a one-dimensional forward transform and is meant to be used twice: once across the rows of a 12x12 tile and once across the columns of the row results. A pass-select input tells the datapath which of the two it is processing. The choice sets how the input lanes are read, how far the sums are scaled down, and how tightly the result is clamped.

Each coefficient is a signed 8-bit constant equal to round(126·cos((2n+1)kπ/24)). Because of the mirror symmetry of the cosine basis, sample n and sample 11−n share a coefficient up to sign. The datapath first adds each mirrored pair for the even frequencies and subtracts it for the odd ones. Each frequency then needs only six constant products. The two highest frequencies are never computed. Each remaining sum is rounded to nearest and then clamped into the legal range for the pass, so it never wraps. The datapath is fully pipelined. It accepts one vector per cycle, and the valid output trails the valid input by three cycles.

Top module: `dct12_core`

## Requirements
- R1: `out_valid` equals the value `in_valid` had three clock edges earlier. A new vector may be presented on every cycle, and each result appears exactly three cycles after its vector.
- R2: Input lane i occupies `in_vec` bits [9i+8:9i]. With `pass_sel`=0, a lane is read as an unsigned pixel 0..255 from its low 8 bits, and bit 8 has no effect on any output. With `pass_sel`=1, the lane is read as a signed two's-complement value −256..255.
- R3: For k in 0..9, output lane k (bits [12k+11:12k] of `out_vec`, signed) is the clamped, rounded value of S_k = Σ x[n]·C[k][n]. Here C[k][n] = round(126·cos((2n+1)kπ/24)), with ties rounded away from zero, so every coefficient fits a signed 8-bit value.
- R4: The rounding adds half an output LSB and then shifts arithmetically toward minus infinity: floor((S_k + 2^(s−1)) / 2^s). The shift s is 8 when `pass_sel`=0 and 7 when `pass_sel`=1.
- R5: With `pass_sel`=0, each result is clamped into −256..255. Values above the range become 255 and values below it become −256.
- R6: With `pass_sel`=1, each result is clamped into −2048..2047. Values above the range become 2047 and values below it become −2048.
- R7: Output lanes 10 and 11 read zero for every input.
- R8: While `rst_n` is low, `out_valid` is 0 and every output lane is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pass_sel | input | 1 | 0 = row pass (unsigned pixels), 1 = column pass (signed values) |
| in_valid | input | 1 | Marks the input vector as meaningful this cycle |
| in_vec | input | 108 | Twelve 9-bit lanes, lane i at bits [9i+8:9i] |
| out_valid | output | 1 | Marks `out_vec` as the result of a vector from three cycles earlier |
| out_vec | output | 144 | Twelve signed 12-bit lanes, lane k at bits [12k+11:12k] |

## Verification
The checker makes several assumptions about the inputs. It assumes `pass_sel` travels with its vector and is sampled on the same edge as `in_valid`, so the clamp range it checks is the one that held three edges earlier. It also assumes that reset is held across at least one rising edge before any check is armed. The bench never changes `pass_sel` between edges. It drives every input on the falling clock edge, keeps reset low for several cycles, and in row passes fills bit 8 of each lane with random values that the design must ignore.

// File: rtl/dct12_pkg.sv
package dct12_pkg;
  localparam int NPTS   = 12;
  localparam int HALF   = NPTS / 2;
  localparam int NACT   = 10;
  localparam int COEF_W = 8;
  localparam int PERIOD = 4 * NPTS;

  // 126*cos(m*pi/24) for m = 0..12, rounded to nearest
  function automatic logic signed [COEF_W-1:0] cos_lvl(input int m);
    case (m)
      0:       cos_lvl = COEF_W'(126);
      1:       cos_lvl = COEF_W'(125);
      2:       cos_lvl = COEF_W'(122);
      3:       cos_lvl = COEF_W'(116);
      4:       cos_lvl = COEF_W'(109);
      5:       cos_lvl = COEF_W'(100);
      6:       cos_lvl = COEF_W'(89);
      7:       cos_lvl = COEF_W'(77);
      8:       cos_lvl = COEF_W'(63);
      9:       cos_lvl = COEF_W'(48);
      10:      cos_lvl = COEF_W'(33);
      11:      cos_lvl = COEF_W'(16);
      default: cos_lvl = '0;
    endcase
  endfunction

  // basis coefficient for frequency k, sample n
  function automatic logic signed [COEF_W-1:0] coef(input int k, input int n);
    int m;
    m = ((2 * n + 1) * k) % PERIOD;
    if (m > PERIOD / 2) m = PERIOD - m;
    if (m <= NPTS) coef = cos_lvl(m);
    else           coef = -cos_lvl(2 * NPTS - m);
  endfunction
endpackage

// File: rtl/dct12_fold.sv
module dct12_fold
  import dct12_pkg::*;
#(
  parameter int IN_W  = 9,
  parameter int SUM_W = IN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    col_pass,
  input  logic [NPTS*IN_W-1:0]    in_vec,
  output logic signed [SUM_W-1:0] sum_q [HALF],
  output logic signed [SUM_W-1:0] dif_q [HALF]
);
  logic signed [IN_W-1:0] lane [NPTS];

  for (genvar i = 0; i < NPTS; i++) begin : g_lane
    assign lane[i] = col_pass ? $signed(in_vec[i*IN_W +: IN_W])
                              : $signed({1'b0, in_vec[i*IN_W +: IN_W-1]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HALF; i++) begin
        sum_q[i] <= '0;
        dif_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < HALF; i++) begin
        sum_q[i] <= SUM_W'(lane[i]) + SUM_W'(lane[NPTS-1-i]);
        dif_q[i] <= SUM_W'(lane[i]) - SUM_W'(lane[NPTS-1-i]);
      end
    end
  end
endmodule

// File: rtl/dct12_mac.sv
module dct12_mac
  import dct12_pkg::*;
#(
  parameter int K     = 0,
  parameter int SUM_W = 10,
  parameter int ACC_W = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [SUM_W-1:0] sum_i [HALF],
  input  logic signed [SUM_W-1:0] dif_i [HALF],
  output logic signed [ACC_W-1:0] acc_q
);
  localparam bit EVEN = (K % 2) == 0;

  logic signed [ACC_W-1:0] acc_d;
  logic signed [SUM_W-1:0] term;

  always_comb begin
    acc_d = '0;
    term  = '0;
    for (int n = 0; n < HALF; n++) begin
      term  = EVEN ? sum_i[n] : dif_i[n];
      acc_d = acc_d + ACC_W'(term) * ACC_W'(coef(K, n));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/dct12_round_sat.sv
module dct12_round_sat #(
  parameter int ACC_W    = 22,
  parameter int OUT_W    = 12,
  parameter int MID_W    = 9,
  parameter int FRAC_ROW = 8,
  parameter int FRAC_COL = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    col_pass,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic                    sat_hi,
  output logic                    sat_lo,
  output logic signed [OUT_W-1:0] res_q
);
  localparam logic signed [ACC_W-1:0] ROW_HALF = ACC_W'(2 ** (FRAC_ROW - 1));
  localparam logic signed [ACC_W-1:0] COL_HALF = ACC_W'(2 ** (FRAC_COL - 1));
  localparam logic signed [ACC_W-1:0] MID_MAX  = ACC_W'(2 ** (MID_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] MID_MIN  = -ACC_W'(2 ** (MID_W - 1));
  localparam logic signed [ACC_W-1:0] WIDE_MAX = ACC_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] WIDE_MIN = -ACC_W'(2 ** (OUT_W - 1));

  logic signed [ACC_W-1:0] shf, lim_hi, lim_lo;

  always_comb begin
    if (col_pass) begin
      shf    = (acc_i + COL_HALF) >>> FRAC_COL;
      lim_hi = WIDE_MAX;
      lim_lo = WIDE_MIN;
    end else begin
      shf    = (acc_i + ROW_HALF) >>> FRAC_ROW;
      lim_hi = MID_MAX;
      lim_lo = MID_MIN;
    end
    sat_hi = shf > lim_hi;
    sat_lo = shf < lim_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (sat_hi) res_q <= OUT_W'(lim_hi);
    else if (sat_lo) res_q <= OUT_W'(lim_lo);
    else             res_q <= OUT_W'(shf);
  end
endmodule

// File: rtl/dct12_core.sv
module dct12_core
  import dct12_pkg::*;
#(
  parameter int IN_W     = 9,
  parameter int OUT_W    = 12,
  parameter int MID_W    = 9,
  parameter int FRAC_ROW = 8,
  parameter int FRAC_COL = 7,
  parameter int ACC_W    = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pass_sel,
  input  logic                    in_valid,
  input  logic [NPTS*IN_W-1:0]    in_vec,
  output logic                    out_valid,
  output logic [NPTS*OUT_W-1:0]   out_vec
);
  localparam int SUM_W = IN_W + 1;
  localparam int LAT   = 3;

  logic signed [SUM_W-1:0] sum_q [HALF];
  logic signed [SUM_W-1:0] dif_q [HALF];
  logic signed [ACC_W-1:0] acc_q [NACT];
  logic signed [OUT_W-1:0] res_q [NACT];
  logic [NACT-1:0]         sat_hi, sat_lo;
  logic [LAT-1:0]          vld_q;
  logic                    pass_q1, pass_q2;

  dct12_fold #(.IN_W(IN_W), .SUM_W(SUM_W)) fold_i (
    .clk(clk), .rst_n(rst_n), .col_pass(pass_sel), .in_vec(in_vec),
    .sum_q(sum_q), .dif_q(dif_q)
  );

  for (genvar k = 0; k < NACT; k++) begin : g_freq
    dct12_mac #(.K(k), .SUM_W(SUM_W), .ACC_W(ACC_W)) mac_i (
      .clk(clk), .rst_n(rst_n), .sum_i(sum_q), .dif_i(dif_q), .acc_q(acc_q[k])
    );
    dct12_round_sat #(
      .ACC_W(ACC_W), .OUT_W(OUT_W), .MID_W(MID_W),
      .FRAC_ROW(FRAC_ROW), .FRAC_COL(FRAC_COL)
    ) rs_i (
      .clk(clk), .rst_n(rst_n), .col_pass(pass_q2), .acc_i(acc_q[k]),
      .sat_hi(sat_hi[k]), .sat_lo(sat_lo[k]), .res_q(res_q[k])
    );
    assign out_vec[k*OUT_W +: OUT_W] = res_q[k];
  end

  for (genvar k = NACT; k < NPTS; k++) begin : g_dead
    assign out_vec[k*OUT_W +: OUT_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      pass_q1 <= 1'b0;
      pass_q2 <= 1'b0;
    end else begin
      vld_q   <= {vld_q[LAT-2:0], in_valid};
      pass_q1 <= pass_sel;
      pass_q2 <= pass_q1;
    end
  end

  assign out_valid = vld_q[LAT-1];
endmodule

// File: rtl/dct12_core_chk.sv
module dct12_core_chk
  import dct12_pkg::*;
#(
  parameter int OUT_W = 12,
  parameter int MID_W = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pass_sel,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic [NPTS*OUT_W-1:0] out_vec,
  input logic                  pass_q2,
  input logic [NACT-1:0]       sat_hi,
  input logic [NACT-1:0]       sat_lo
);
  localparam logic signed [OUT_W-1:0] MID_MAX  = OUT_W'(2 ** (MID_W - 1) - 1);
  localparam logic signed [OUT_W-1:0] MID_MIN  = -OUT_W'(2 ** (MID_W - 1));
  localparam logic signed [OUT_W-1:0] WIDE_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] WIDE_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  for (genvar k = 0; k < NACT; k++) begin : g_lane
    logic signed [OUT_W-1:0] lane;
    assign lane = $signed(out_vec[k*OUT_W +: OUT_W]);

    assert_clamp_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_hi[k] && !pass_q2) |=> (lane == MID_MAX));
    assert_clamp_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_lo[k] && !pass_q2) |=> (lane == MID_MIN));
    assert_clamp_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_hi[k] && pass_q2) |=> (lane == WIDE_MAX));
    assert_clamp_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_lo[k] && pass_q2) |=> (lane == WIDE_MIN));
    assert_row_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && out_valid && !$past(pass_sel, 3))
        |-> (lane >= MID_MIN && lane <= MID_MAX));
  end
endmodule

bind dct12_core dct12_core_chk #(.OUT_W(OUT_W), .MID_W(MID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pass_sel(pass_sel), .in_valid(in_valid),
  .out_valid(out_valid), .out_vec(out_vec), .pass_q2(pass_q2),
  .sat_hi(sat_hi), .sat_lo(sat_lo)
);

// File: tb/dct12_core_tb_top.sv
`timescale 1ns/1ps
module dct12_core_tb_top;
  localparam int NP = 12, NA = 10, IN_W = 9, OUT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pass_sel = 1'b0;
  logic in_valid = 1'b0;
  logic [NP*IN_W-1:0]  in_vec = '0;
  logic                out_valid;
  logic [NP*OUT_W-1:0] out_vec;

  always #2.5 clk = ~clk;

  dct12_core dut_i (
    .clk(clk), .rst_n(rst_n), .pass_sel(pass_sel), .in_valid(in_valid),
    .in_vec(in_vec), .out_valid(out_valid), .out_vec(out_vec)
  );

  int checks = 0, fails = 0;
  int vals [NP];

  function automatic int cq(int k, int n);
    real v;
    v = 126.0 * $cos(real'((2 * n + 1) * k) * 3.14159265358979 / 24.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int model(int v [NP], bit col, int k);
    int acc, sh, r, hi, lo;
    if (k >= NA) return 0;
    acc = 0;
    for (int n = 0; n < NP; n++) acc += v[n] * cq(k, n);
    sh = col ? 7 : 8;
    r  = (acc + (1 << (sh - 1))) >>> sh;
    hi = col ? 2047 : 255;
    lo = col ? -2048 : -256;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  task automatic chk(int act, int exp, string req, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lane_out(int k);
    return int'($signed(out_vec[k*OUT_W +: OUT_W]));
  endfunction

  task automatic check_vec(int v [NP], bit col, string req);
    for (int k = 0; k < NP; k++)
      chk(lane_out(k), model(v, col, k), (k >= NA) ? "R7" : req, $sformatf("lane%0d", k));
  endtask

  // row pass: bit 8 of each lane is random junk (R2)
  function automatic logic [NP*IN_W-1:0] pack(int v [NP], bit col);
    logic [NP*IN_W-1:0] r;
    for (int i = 0; i < NP; i++)
      r[i*IN_W +: IN_W] = col ? IN_W'(v[i]) : {1'($urandom), 8'(v[i])};
    return r;
  endfunction

  task automatic run_one(bit col, string req);
    @(negedge clk);
    in_vec = pack(vals, col); pass_sel = col; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(int'(out_valid), 1, "R1", "valid at latency 3");
    check_vec(vals, col, req);
    @(negedge clk);
    chk(int'(out_valid), 0, "R1", "valid drops");
  endtask

  task automatic fill(int x);
    for (int i = 0; i < NP; i++) vals[i] = x;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int amp0 [3] = '{255, 1, 128};
    int amp1 [5] = '{255, -256, -1, 4, -4};
    int bv [4][NP];
    bit bp [4];

    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(int'(out_valid), 0, "R8", "valid in reset");
    for (int k = 0; k < NP; k++) chk(lane_out(k), 0, "R8", $sformatf("lane%0d in reset", k));
    rst_n = 1'b1;

    // R3: impulse sweep, row pass
    for (int n = 0; n < NP; n++)
      for (int a = 0; a < 3; a++) begin
        fill(0); vals[n] = amp0[a]; run_one(1'b0, "R3");
      end
    // R4: impulse sweep, column pass, including half-LSB ties
    for (int n = 0; n < NP; n++)
      for (int a = 0; a < 5; a++) begin
        fill(0); vals[n] = amp1[a]; run_one(1'b1, "R4");
      end
    // R4 directed ties: x5 = -4 gives S1 = -64, x5 = 4 gives S1 = 64
    fill(0); vals[5] = -4; run_one(1'b1, "R4");
    chk(lane_out(1), 0, "R4", "tie -64 rounds up to 0");
    fill(0); vals[5] = 4; run_one(1'b1, "R4");
    chk(lane_out(1), 1, "R4", "tie 64 rounds up to 1");

    // R5: row saturation
    fill(255); run_one(1'b0, "R5");
    chk(lane_out(0), 255, "R5", "DC clamp high");
    for (int i = 0; i < NP; i++) vals[i] = (i % 2) ? 0 : 255;
    run_one(1'b0, "R5");
    // R6: column saturation both ways
    fill(255); run_one(1'b1, "R6");
    chk(lane_out(0), 2047, "R6", "DC clamp high");
    fill(-256); run_one(1'b1, "R6");
    chk(lane_out(0), -2048, "R6", "DC clamp low");
    for (int i = 0; i < NP; i++) vals[i] = (i < 6) ? 255 : -256;
    run_one(1'b1, "R6");

    // R2 / R3: random vectors in both passes
    for (int t = 0; t < 150; t++) begin
      for (int i = 0; i < NP; i++) vals[i] = int'($urandom_range(0, 255));
      run_one(1'b0, "R2");
    end
    for (int t = 0; t < 150; t++) begin
      for (int i = 0; i < NP; i++) vals[i] = int'($urandom_range(0, 511)) - 256;
      run_one(1'b1, "R3");
    end

    // R1: back-to-back vectors with mixed passes
    for (int j = 0; j < 4; j++) begin
      bp[j] = j[0];
      for (int i = 0; i < NP; i++)
        bv[j][i] = bp[j] ? int'($urandom_range(0, 511)) - 256 : int'($urandom_range(0, 255));
    end
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (c >= 3 && c < 7) begin
        chk(int'(out_valid), 1, "R1", $sformatf("burst valid %0d", c - 3));
        check_vec(bv[c-3], bp[c-3], "R1");
      end
      if (c == 7) chk(int'(out_valid), 0, "R1", "burst valid drops");
      if (c < 4) begin
        in_vec = pack(bv[c], bp[c]); pass_sel = bp[c]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule